// File: doc/BRIEF.md
# Bus Transaction Status and Interrupt Register

This block collects the outcome of bus transactions for a host interface that can act both as initiator and as responder on a parallel bus. The bus engine reports each event as a one-cycle strobe: a disconnect by the far end, a target abort, a master abort, a data parity error (seen locally or reported by the host), an address parity error, and the completion of a transaction that this side initiated. The block keeps each of these in a sticky status bit that software clears by writing a one. Each bit is ANDed with an enable bit and registered into one of four level interrupt requests.

Some events have side effects on other bits. The abort events also set mirrored configuration-status bits. An address parity error also sets a detected-parity configuration bit. When system-error reporting is enabled, it also produces a one-cycle system-error pulse and sets a signalled-error bit. Parity errors are collected while a transfer is in flight and are committed only at its end. They are dropped while the soft-reset level is high. A separate two-state machine raises an address-request flag when the next initiator address may be loaded.

Two state machines carry the sequencing. The parity collector has the states CLEAN, DATA, ADDR and BOTH. It moves from CLEAN to DATA or ADDR on a qualified error, to BOTH once both kinds are pending, and back to CLEAN on the end-of-transfer strobe. The address-request machine has the states IDLE and REQ. It moves from IDLE to REQ on a set condition. It moves from REQ to IDLE on an address write, on mastering being disabled, or on soft reset.

Top module: `xfer_status_intc`

## Requirements
- R1: After hard reset, every status, enable and configuration bit reads 0, all four interrupt outputs are 0 and `serr_pulse` is 0.
- R2: A strobe on `ev_tdisc`, `ev_tabort` or `ev_mabort` sets status bit 0, 1 or 2 at that clock edge. A target abort also sets configuration bit 0 and a master abort also sets configuration bit 1 at the same edge.
- R3: A register write with selector 0 clears each status bit 0..4 whose data bit is 1, and leaves bits written 0 unchanged. A write with selector 2 does the same for configuration bits 0..3. If a set event and a clear land on one bit in the same cycle, the bit ends set.
- R4: The interrupt outputs follow the status and enable bits one cycle later:
  - `irq_term` = status0 & enable0
  - `irq_abort` = (status1 | status2) & enable1
  - `irq_parity` = (status3 | status4) & enable2
  - `irq_maddr` = status5 & enable3
- R5: A data parity error (`ev_dpar_local` or `ev_dpar_host`) is collected only when `bus_mode` is 1 and either `is_master` or `is_sel_target` is 1. Status bit 3 is set at the edge where `xfer_end` is high, and not before.
- R6: An address parity error (`ev_apar`) is collected only when `bus_mode` and `is_target` are 1. At the `xfer_end` edge it sets status bit 4 and configuration bit 2.
- R7: If `serr_en` is 1 at the edge that commits an address parity error, `serr_pulse` is high for exactly the following cycle and configuration bit 3 is set at that edge.
- R8: While `soft_rst` is 1 at the `xfer_end` edge, no parity bit, configuration bit 2 or 3, or `serr_pulse` is set. The bits already held keep their values.
- R9: Status bit 5 (address request) is set when `bm_en` is 1, `soft_rst` is 0, and either `bus_mode` rises (0 in the previous cycle, 1 now, counting the first cycle after reset) or `ev_mxfer_done` is high.
- R10: Status bit 5 clears on `next_addr_wr`, when `bm_en` is 0, or while `soft_rst` is 1. Disabling and soft reset override a set condition. A set condition overrides an address write in the same cycle.
- R11: `reg_rdata` is combinational from `reg_sel`:
  - 0 gives status bits [5:0]
  - 1 gives enables [3:0]
  - 2 gives configuration bits [3:0]
  - 3 gives zero
  - unused upper bits are 0
  - a write with selector 1 loads the enables from `reg_wdata[3:0]`
- R12: Writing a 1 to status bit 5 through selector 0 has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Hard reset, active low |
| soft_rst | input | 1 | Soft-reset level |
| bus_mode | input | 1 | Bus mode active |
| is_master | input | 1 | This side initiates the current transfer |
| is_sel_target | input | 1 | This side is the selected responder |
| is_target | input | 1 | This side is acting as responder |
| bm_en | input | 1 | Bus mastering enabled |
| serr_en | input | 1 | System-error reporting enabled |
| ev_tdisc | input | 1 | Transfer ended by far-end disconnect |
| ev_tabort | input | 1 | Transfer ended by target abort |
| ev_mabort | input | 1 | Transfer ended by master abort |
| ev_dpar_local | input | 1 | Locally detected data parity error |
| ev_dpar_host | input | 1 | Host-reported data parity error |
| ev_apar | input | 1 | Address parity error detected |
| xfer_end | input | 1 | End-of-transfer strobe |
| ev_mxfer_done | input | 1 | Initiated transfer completed |
| next_addr_wr | input | 1 | Next-address register written |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data |
| irq_term | output | 1 | Termination interrupt request |
| irq_abort | output | 1 | Abort interrupt request |
| irq_parity | output | 1 | Parity interrupt request |
| irq_maddr | output | 1 | Address-request interrupt |
| cfg_status | output | 4 | Mirrored configuration status bits |
| serr_pulse | output | 1 | One-cycle system-error pulse |

## Verification
Two functions can fall in the same cycle and contend for one bit. The first is a write-one-to-clear of a status or configuration bit in the same cycle as an event that sets it. The second is an address-register write in the same cycle as a completed initiated transfer on the address-request flag. Directed steps drive each pair in one cycle on purpose. Random traffic with dense strobes and frequent writes repeats the collisions many times. The outcome is judged against a behavioural model that applies the stated priority on every clock.

// File: rtl/xsi_pkg.sv
package xsi_pkg;
    localparam int ST_DISC = 0;
    localparam int ST_TABT = 1;
    localparam int ST_MABT = 2;
    localparam int ST_DPAR = 3;
    localparam int ST_APAR = 4;
    localparam int ST_AREQ = 5;
    localparam int NSTICKY = 5;
    localparam int NSTAT   = NSTICKY + 1;

    localparam int EN_TERM = 0;
    localparam int EN_ABT  = 1;
    localparam int EN_PAR  = 2;
    localparam int EN_MADR = 3;
    localparam int NEN     = 4;

    localparam int CF_RTA  = 0;
    localparam int CF_RMA  = 1;
    localparam int CF_DPE  = 2;
    localparam int CF_SSE  = 3;
    localparam int NCFG    = 4;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_CFG    = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        AR_IDLE = 1'b0,
        AR_REQ  = 1'b1
    } areq_state_e;

    typedef enum logic [1:0] {
        PC_CLEAN = 2'd0,
        PC_DATA  = 2'd1,
        PC_ADDR  = 2'd2,
        PC_BOTH  = 2'd3
    } pcap_state_e;
endpackage

// File: rtl/xsi_w1c_bank.sv
module xsi_w1c_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_o[g] <= 1'b0;
            else if (set_i[g])
                q_o[g] <= 1'b1;
            else if (clr_i[g])
                q_o[g] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> q_o[g]); // R3
        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !q_o[g]); // R3
    end
endmodule

// File: rtl/xsi_parity_capture.sv
module xsi_parity_capture
    import xsi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dp_hit,
    input  logic ap_hit,
    input  logic xfer_end,
    input  logic soft_rst,
    input  logic serr_en,
    output logic dpar_set,
    output logic apar_set,
    output logic sse_set,
    output logic serr_o
);
    pcap_state_e state_q, state_d;
    logic        has_d, has_a, commit;
    logic        serr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PC_CLEAN;
            serr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            serr_q  <= sse_set;
        end
    end

    always_comb begin
        has_d = dp_hit;
        has_a = ap_hit;
        unique case (state_q)
            PC_CLEAN: ;
            PC_DATA:  has_d = 1'b1;
            PC_ADDR:  has_a = 1'b1;
            PC_BOTH:  begin
                has_d = 1'b1;
                has_a = 1'b1;
            end
        endcase
        if (xfer_end)
            state_d = PC_CLEAN;
        else if (has_d && has_a)
            state_d = PC_BOTH;
        else if (has_a)
            state_d = PC_ADDR;
        else if (has_d)
            state_d = PC_DATA;
        else
            state_d = PC_CLEAN;
    end

    always_comb begin
        commit   = xfer_end && !soft_rst;
        dpar_set = commit && has_d;
        apar_set = commit && has_a;
        sse_set  = apar_set && serr_en;
        serr_o   = serr_q;
    end

    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end |=> (state_q == PC_CLEAN)); // R5
endmodule

// File: rtl/xsi_addr_req.sv
module xsi_addr_req
    import xsi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic bm_en,
    input  logic bus_mode,
    input  logic mxfer_done,
    input  logic next_addr_wr,
    output logic areq_o
);
    areq_state_e state_q, state_d;
    logic        mode_q, set_cond;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AR_IDLE;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= bus_mode;
        end
    end

    always_comb begin
        set_cond = (bus_mode && !mode_q) || mxfer_done;
        state_d  = state_q;
        unique case (state_q)
            AR_IDLE: if (bm_en && !soft_rst && set_cond) state_d = AR_REQ;
            AR_REQ: begin
                if (soft_rst || !bm_en)
                    state_d = AR_IDLE;
                else if (next_addr_wr && !set_cond)
                    state_d = AR_IDLE;
            end
        endcase
    end

    always_comb begin
        areq_o = (state_q == AR_REQ);
    end

    AST_AREQ_NEEDS_BM: assert property (@(posedge clk) disable iff (!rst_n)
        areq_o |-> $past(bm_en)); // R10
    AST_AREQ_SOFT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> !areq_o); // R10
    AST_AREQ_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mxfer_done && bm_en && !soft_rst) |=> areq_o); // R9
endmodule

// File: rtl/xfer_status_intc.sv
module xfer_status_intc
    import xsi_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          bus_mode,
    input  logic          is_master,
    input  logic          is_sel_target,
    input  logic          is_target,
    input  logic          bm_en,
    input  logic          serr_en,
    input  logic          ev_tdisc,
    input  logic          ev_tabort,
    input  logic          ev_mabort,
    input  logic          ev_dpar_local,
    input  logic          ev_dpar_host,
    input  logic          ev_apar,
    input  logic          xfer_end,
    input  logic          ev_mxfer_done,
    input  logic          next_addr_wr,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_term,
    output logic          irq_abort,
    output logic          irq_parity,
    output logic          irq_maddr,
    output logic [3:0]    cfg_status,
    output logic          serr_pulse
);
    localparam int NIRQ = NEN;

    logic [NSTICKY-1:0] sts_set, sts_clr, sts_q;
    logic [NCFG-1:0]    cfg_set, cfg_clr, cfg_q;
    logic [NEN-1:0]     en_q;
    logic [NIRQ-1:0]    irq_q, irq_d;
    logic [NSTAT-1:0]   status_vec;
    logic               dp_hit, ap_hit;
    logic               dpar_set, apar_set, sse_set, serr_w;
    logic               areq;
    reg_sel_e           sel;
    logic               unused_wbits;

    assign sel          = reg_sel_e'(reg_sel);
    assign unused_wbits = ^reg_wdata[DW-1:NSTICKY];

    // qualification of parity errors by operating role
    assign dp_hit = (ev_dpar_local || ev_dpar_host) && bus_mode && (is_master || is_sel_target);
    assign ap_hit = ev_apar && bus_mode && is_target;

    xsi_parity_capture u_pcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .dp_hit   (dp_hit),
        .ap_hit   (ap_hit),
        .xfer_end (xfer_end),
        .soft_rst (soft_rst),
        .serr_en  (serr_en),
        .dpar_set (dpar_set),
        .apar_set (apar_set),
        .sse_set  (sse_set),
        .serr_o   (serr_w)
    );

    xsi_addr_req u_areq (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .bm_en        (bm_en),
        .bus_mode     (bus_mode),
        .mxfer_done   (ev_mxfer_done),
        .next_addr_wr (next_addr_wr),
        .areq_o       (areq)
    );

    always_comb begin
        sts_set          = '0;
        sts_set[ST_DISC] = ev_tdisc;
        sts_set[ST_TABT] = ev_tabort;
        sts_set[ST_MABT] = ev_mabort;
        sts_set[ST_DPAR] = dpar_set;
        sts_set[ST_APAR] = apar_set;
        sts_clr          = (reg_wr && sel == SEL_STATUS) ? reg_wdata[NSTICKY-1:0] : '0;

        cfg_set          = '0;
        cfg_set[CF_RTA]  = ev_tabort;
        cfg_set[CF_RMA]  = ev_mabort;
        cfg_set[CF_DPE]  = apar_set;
        cfg_set[CF_SSE]  = sse_set;
        cfg_clr          = (reg_wr && sel == SEL_CFG) ? reg_wdata[NCFG-1:0] : '0;
    end

    xsi_w1c_bank #(.N(NSTICKY)) u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (sts_set),
        .clr_i (sts_clr),
        .q_o   (sts_q)
    );

    xsi_w1c_bank #(.N(NCFG)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (cfg_set),
        .clr_i (cfg_clr),
        .q_o   (cfg_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (reg_wr && sel == SEL_ENABLE)
            en_q <= reg_wdata[NEN-1:0];
    end

    always_comb begin
        irq_d          = '0;
        irq_d[EN_TERM] = sts_q[ST_DISC] && en_q[EN_TERM];
        irq_d[EN_ABT]  = (sts_q[ST_TABT] || sts_q[ST_MABT]) && en_q[EN_ABT];
        irq_d[EN_PAR]  = (sts_q[ST_DPAR] || sts_q[ST_APAR]) && en_q[EN_PAR];
        irq_d[EN_MADR] = areq && en_q[EN_MADR];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= '0;
        else
            irq_q <= irq_d;
    end

    assign status_vec = {areq, sts_q};

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_STATUS: reg_rdata[NSTAT-1:0] = status_vec;
            SEL_ENABLE: reg_rdata[NEN-1:0]   = en_q;
            SEL_CFG:    reg_rdata[NCFG-1:0]  = cfg_q;
            SEL_NONE:   reg_rdata            = '0;
        endcase
    end

    assign irq_term   = irq_q[EN_TERM];
    assign irq_abort  = irq_q[EN_ABT];
    assign irq_parity = irq_q[EN_PAR];
    assign irq_maddr  = irq_q[EN_MADR];
    assign cfg_status = cfg_q;
    assign serr_pulse = serr_w;

    AST_ABT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tabort |=> (cfg_status[CF_RTA] && sts_q[ST_TABT])); // R2
    AST_IRQ_TERM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_term |-> $past(sts_q[ST_DISC] && en_q[EN_TERM])); // R4
    AST_DPAR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[ST_DPAR]) |-> $past(xfer_end)); // R5
    AST_SERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pulse |-> (sts_q[ST_APAR] && cfg_status[CF_SSE] && $past(serr_en))); // R7
    AST_SOFT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(soft_rst) && !$past(sts_q[ST_DPAR])) |-> !sts_q[ST_DPAR]); // R8
endmodule

// File: tb/sim_xfer_status_intc.sv
module sim_xfer_status_intc;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 0, bus_mode = 0, is_master = 0, is_sel_target = 0, is_target = 0;
    logic bm_en = 0, serr_en = 0;
    logic ev_tdisc = 0, ev_tabort = 0, ev_mabort = 0, ev_dpar_local = 0, ev_dpar_host = 0;
    logic ev_apar = 0, xfer_end = 0, ev_mxfer_done = 0, next_addr_wr = 0, reg_wr = 0;
    logic [1:0]    reg_sel = 0;
    logic [DW-1:0] reg_wdata = 0;
    logic [DW-1:0] reg_rdata;
    logic irq_term, irq_abort, irq_parity, irq_maddr, serr_pulse;
    logic [3:0] cfg_status;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    xfer_status_intc #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_mode(bus_mode),
        .is_master(is_master), .is_sel_target(is_sel_target), .is_target(is_target),
        .bm_en(bm_en), .serr_en(serr_en), .ev_tdisc(ev_tdisc), .ev_tabort(ev_tabort),
        .ev_mabort(ev_mabort), .ev_dpar_local(ev_dpar_local), .ev_dpar_host(ev_dpar_host),
        .ev_apar(ev_apar), .xfer_end(xfer_end), .ev_mxfer_done(ev_mxfer_done),
        .next_addr_wr(next_addr_wr), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_term(irq_term),
        .irq_abort(irq_abort), .irq_parity(irq_parity), .irq_maddr(irq_maddr),
        .cfg_status(cfg_status), .serr_pulse(serr_pulse)
    );

    // behavioural reference model
    bit [5:0] m_sts;
    bit [3:0] m_en, m_cfg, m_irq;
    bit m_dpend, m_apend, m_serr, m_modeq;

    always @(posedge clk) begin
        bit dtot, atot, commit;
        bit [5:0] w1c;
        if (!rst_n) begin
            m_sts = 0; m_en = 0; m_cfg = 0; m_irq = 0;
            m_dpend = 0; m_apend = 0; m_serr = 0; m_modeq = 0;
        end else begin
            m_irq[0] = m_sts[0] & m_en[0];
            m_irq[1] = (m_sts[1] | m_sts[2]) & m_en[1];
            m_irq[2] = (m_sts[3] | m_sts[4]) & m_en[2];
            m_irq[3] = m_sts[5] & m_en[3];
            dtot = m_dpend | ((ev_dpar_local | ev_dpar_host) & bus_mode & (is_master | is_sel_target));
            atot = m_apend | (ev_apar & bus_mode & is_target);
            commit = xfer_end & ~soft_rst;
            m_dpend = xfer_end ? 1'b0 : dtot;
            m_apend = xfer_end ? 1'b0 : atot;
            w1c = (reg_wr && reg_sel == 2'd0) ? {1'b0, reg_wdata[4:0]} : 6'd0;
            m_sts[4:0] = m_sts[4:0] & ~w1c[4:0];
            if (ev_tdisc) m_sts[0] = 1;
            if (ev_tabort) m_sts[1] = 1;
            if (ev_mabort) m_sts[2] = 1;
            if (commit && dtot) m_sts[3] = 1;
            if (commit && atot) m_sts[4] = 1;
            if (reg_wr && reg_sel == 2'd2) m_cfg = m_cfg & ~reg_wdata[3:0];
            if (ev_tabort) m_cfg[0] = 1;
            if (ev_mabort) m_cfg[1] = 1;
            if (commit && atot) m_cfg[2] = 1;
            if (commit && atot && serr_en) m_cfg[3] = 1;
            m_serr = commit & atot & serr_en;
            if (reg_wr && reg_sel == 2'd1) m_en = reg_wdata[3:0];
            if (soft_rst || !bm_en) m_sts[5] = 0;
            else if ((bus_mode && !m_modeq) || ev_mxfer_done) m_sts[5] = 1;
            else if (next_addr_wr) m_sts[5] = 0;
            m_modeq = bus_mode;
        end
    end

    function automatic logic [DW-1:0] m_read(input logic [1:0] s);
        case (s)
            2'd0: return {2'b0, m_sts};
            2'd1: return {4'b0, m_en};
            2'd2: return {4'b0, m_cfg};
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 irq outputs", {4'b0, irq_maddr, irq_parity, irq_abort, irq_term}, {4'b0, m_irq});
            chk("R2 R6 cfg_status", {4'b0, cfg_status}, {4'b0, m_cfg});
            chk("R7 serr_pulse", {7'b0, serr_pulse}, {7'b0, m_serr});
            chk("R11 reg_rdata", reg_rdata, m_read(reg_sel));
        end
    end

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic quiet();
        ev_tdisc = 0; ev_tabort = 0; ev_mabort = 0; ev_dpar_local = 0; ev_dpar_host = 0;
        ev_apar = 0; xfer_end = 0; ev_mxfer_done = 0; next_addr_wr = 0; reg_wr = 0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [DW-1:0] d);
        reg_wr = 1; reg_sel = s; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [DW-1:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] v;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        rd(2'd0, v); chk("R1 status after reset", v, 8'h00);
        rd(2'd1, v); chk("R1 enables after reset", v, 8'h00);
        rd(2'd2, v); chk("R1 cfg after reset", v, 8'h00);
        chk("R1 irq/serr after reset", {3'b0, irq_term, irq_abort, irq_parity, irq_maddr, serr_pulse}, 8'h00);

        wr(2'd1, 8'h0F);
        rd(2'd1, v); chk("R11 enable readback", v, 8'h0F);
        rd(2'd3, v); chk("R11 selector 3 reads zero", v, 8'h00);

        // R2 disconnect and aborts
        ev_tdisc = 1; tick(); quiet();
        rd(2'd0, v); chk("R2 disconnect bit", v & 8'h01, 8'h01);
        tick(); chk("R4 irq_term", {7'b0, irq_term}, 8'h01);
        ev_tabort = 1; tick(); quiet();
        chk("R2 target abort mirror", {4'b0, cfg_status} & 8'h01, 8'h01);
        tick(); chk("R4 irq_abort", {7'b0, irq_abort}, 8'h01);

        // R3 write-one-to-clear collisions
        ev_tdisc = 1; reg_wr = 1; reg_sel = 2'd0; reg_wdata = 8'h01; tick(); quiet();
        rd(2'd0, v); chk("R3 set beats clear", v & 8'h01, 8'h01);
        wr(2'd0, 8'h01);
        rd(2'd0, v); chk("R3 clear by one", v & 8'h03, 8'h02);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R3 zero write no effect", v & 8'h02, 8'h02);
        wr(2'd0, 8'h1F); wr(2'd2, 8'h0F);
        rd(2'd2, v); chk("R3 cfg cleared", v, 8'h00);

        // R5 data parity only at end of transfer
        bus_mode = 1; is_master = 1;
        ev_dpar_local = 1; tick(); quiet();
        rd(2'd0, v); chk("R5 no record mid-transfer", v & 8'h08, 8'h00);
        xfer_end = 1; tick(); quiet();
        rd(2'd0, v); chk("R5 recorded at end", v & 8'h08, 8'h08);
        wr(2'd0, 8'h08);
        is_master = 0; is_sel_target = 0;
        ev_dpar_host = 1; xfer_end = 1; tick(); quiet();
        rd(2'd0, v); chk("R5 ignored when not master/selected", v & 8'h08, 8'h00);

        // R6 R7 address parity with system error
        is_target = 1; serr_en = 1;
        ev_apar = 1; xfer_end = 1; tick(); quiet();
        rd(2'd0, v); chk("R6 address parity bit", v & 8'h10, 8'h10);
        chk("R6 R7 cfg dpe and sse", {4'b0, cfg_status} & 8'h0C, 8'h0C);
        chk("R7 serr pulse high", {7'b0, serr_pulse}, 8'h01);
        tick(); chk("R7 serr pulse one cycle", {7'b0, serr_pulse}, 8'h00);

        // R8 soft reset blocks parity capture
        wr(2'd0, 8'h18); wr(2'd2, 8'h0C);
        soft_rst = 1;
        ev_apar = 1; ev_dpar_local = 1; is_master = 1; xfer_end = 1; tick(); quiet();
        rd(2'd0, v); chk("R8 no parity record in soft reset", v & 8'h18, 8'h00);
        chk("R8 no serr in soft reset", {3'b0, cfg_status, serr_pulse} & 8'h19, 8'h00);
        soft_rst = 0;

        // R9 R10 R12 address request
        bm_en = 1; bus_mode = 0; tick(); bus_mode = 1; tick();
        rd(2'd0, v); chk("R9 set on bus-mode entry", v & 8'h20, 8'h20);
        wr(2'd0, 8'h20);
        rd(2'd0, v); chk("R12 write-one ignored on bit 5", v & 8'h20, 8'h20);
        next_addr_wr = 1; tick(); quiet();
        rd(2'd0, v); chk("R10 cleared by address write", v & 8'h20, 8'h00);
        ev_mxfer_done = 1; next_addr_wr = 1; tick(); quiet();
        rd(2'd0, v); chk("R10 set beats address write", v & 8'h20, 8'h20);
        bm_en = 0; ev_mxfer_done = 1; tick(); quiet();
        rd(2'd0, v); chk("R10 cleared by disable", v & 8'h20, 8'h00);

        // random traffic, compared each cycle by the model
        for (int i = 0; i < 4000; i++) begin
            soft_rst      = ($urandom_range(0, 19) == 0);
            bm_en         = ($urandom_range(0, 9) != 0);
            if ($urandom_range(0, 29) == 0) bus_mode = ~bus_mode;
            is_master     = $urandom_range(0, 1);
            is_sel_target = $urandom_range(0, 1);
            is_target     = $urandom_range(0, 1);
            serr_en       = $urandom_range(0, 1);
            ev_tdisc      = ($urandom_range(0, 9) == 0);
            ev_tabort     = ($urandom_range(0, 9) == 0);
            ev_mabort     = ($urandom_range(0, 9) == 0);
            ev_dpar_local = ($urandom_range(0, 9) == 0);
            ev_dpar_host  = ($urandom_range(0, 9) == 0);
            ev_apar       = ($urandom_range(0, 9) == 0);
            xfer_end      = ($urandom_range(0, 5) == 0);
            ev_mxfer_done = ($urandom_range(0, 9) == 0);
            next_addr_wr  = ($urandom_range(0, 7) == 0);
            reg_wr        = ($urandom_range(0, 4) == 0);
            reg_sel       = 2'($urandom_range(0, 3));
            reg_wdata     = 8'($urandom);
            tick();
        end
        quiet();
        tick();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule